// File: doc/BRIEF.md
# Interrupt Status Aggregator with Toggle-on-Write Clearing

This block gathers the interrupt sources of a serial peripheral controller into one status word, qualifies that word with a per-source enable mask and a single global enable, and drives one registered interrupt line. The datapath around it reports two kinds of condition. Single-cycle event pulses mark a completed byte exchange, a transmit underrun, a transmit FIFO reaching half empty, and a receive overrun. Level inputs show that the receive FIFO holds data or is full.

Software reaches the three registers through a simple word interface. A write to the status word XORs the written value into the stored bits. Writing a one to a set bit therefore clears it, and writing a one to a clear bit sets it. The two receive level conditions are ORed back into the status every cycle, so a bit driven by one of them cannot stay cleared while its condition holds.

The interrupt line is a flip-flop. It follows the registered state one clock edge later.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word, the enable mask, the global enable and `irq_o` are all zero.
- R2: The global-enable register sits at byte offset 0x1C. Only bit 31 of it is stored, and every other bit reads as zero.
- R3: The enable-mask register sits at offset 0x28. It stores only the defined source positions (mask 0x17C), and every other bit reads as zero.
- R4: A write to the status register at offset 0x20 XORs the written data into the stored status bits.
- R5: A byte-exchange pulse sets status bits 2 (transmit empty) and 8 (receive has data). An underrun pulse sets bit 3, a half-empty pulse sets bit 6 and an overrun pulse sets bit 5.
- R6: While the receive-has-data level is high, bit 8 reads as set after every clock edge. While the receive-full level is high, bit 4 reads as set after every clock edge. This holds even across a write that toggles those bits.
- R7: When a source input and a toggle write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_o` is a register. At each edge it loads (global enable AND any bit of status AND mask), using the register values from before that edge.
- R9: Status positions other than 2, 3, 4, 5, 6 and 8 always read as zero, and any offset other than 0x1C, 0x20 and 0x28 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_addr | input | 8 | Byte offset used for both writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| xfer_done_i | input | 1 | Pulse: one byte exchanged |
| tx_underrun_i | input | 1 | Pulse: transmit underrun |
| tx_half_empty_i | input | 1 | Pulse: transmit FIFO at half empty |
| rx_overrun_i | input | 1 | Pulse: receive overrun |
| rx_not_empty_i | input | 1 | Level: receive FIFO holds data |
| rx_full_i | input | 1 | Level: receive FIFO is full |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets the XOR semantics from both directions.

- Writing a one to a clear bit must set it. A design that treats the write as write-one-to-clear would leave that bit low.
- Clearing a level-backed bit while its condition persists must fail. A design that does not reassert every cycle would lose the bit.
- A toggle write and a byte-exchange pulse on the same bit must leave it set. A design with the wrong priority would drop the event.
- Upper-bit writes to the enable and global-enable registers are checked. A design with an unmasked register would read back the extra bits.
- `irq_o` is sampled on the cycle before and the cycle after it should change. A combinational or two-stage output would show up one edge off.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned BIT_TX_EMPTY    = 2;
  localparam int unsigned BIT_TX_UNDERRUN = 3;
  localparam int unsigned BIT_RX_FULL     = 4;
  localparam int unsigned BIT_RX_OVERRUN  = 5;
  localparam int unsigned BIT_TX_HALF     = 6;
  localparam int unsigned BIT_RX_NONEMPTY = 8;
  localparam int unsigned BIT_GLOBAL_EN   = DW - 1;

  typedef logic [DW-1:0] word_t;

  // Sources feeding the status word
  typedef struct packed {
    logic xfer_done;
    logic tx_underrun;
    logic tx_half_empty;
    logic rx_overrun;
    logic rx_not_empty;
    logic rx_full;
  } irq_src_t;

  function automatic word_t one_hot(input int unsigned pos);
    word_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction

  localparam word_t DEFINED_MASK = one_hot(BIT_TX_EMPTY) | one_hot(BIT_TX_UNDERRUN) |
                                   one_hot(BIT_RX_FULL) | one_hot(BIT_RX_OVERRUN) |
                                   one_hot(BIT_TX_HALF) | one_hot(BIT_RX_NONEMPTY);

  // Bits forced high this cycle by the datapath
  function automatic word_t set_vector(input irq_src_t s);
    word_t w;
    w = '0;
    if (s.xfer_done) begin
      w[BIT_TX_EMPTY]    = 1'b1;
      w[BIT_RX_NONEMPTY] = 1'b1;
    end
    if (s.tx_underrun)   w[BIT_TX_UNDERRUN] = 1'b1;
    if (s.tx_half_empty) w[BIT_TX_HALF]     = 1'b1;
    if (s.rx_overrun)    w[BIT_RX_OVERRUN]  = 1'b1;
    if (s.rx_not_empty)  w[BIT_RX_NONEMPTY] = 1'b1;
    if (s.rx_full)       w[BIT_RX_FULL]     = 1'b1;
    return w;
  endfunction

  // Toggle first, then sources win
  function automatic word_t status_next(input word_t cur, input logic wr,
                                        input word_t wd, input word_t setv);
    word_t t;
    t = wr ? (cur ^ wd) : cur;
    return (t | setv) & DEFINED_MASK;
  endfunction

  function automatic logic irq_pending(input word_t st, input word_t en, input logic ge);
    return ge & (|(st & en));
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_toggle,
  input  word_t    wdata,
  input  irq_src_t src,
  output word_t    status_q
);
  word_t set_v;
  word_t status_d;

  assign set_v    = set_vector(src);
  assign status_d = status_next(status_q, wr_toggle, wdata, set_v);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R6
  rx_level_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src.rx_not_empty |=> status_q[BIT_RX_NONEMPTY]);

  // R5
  xfer_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src.xfer_done |=> (status_q[BIT_TX_EMPTY] && status_q[BIT_RX_NONEMPTY]));

  // R4
  toggle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_toggle && (set_v == '0)) |=>
      (status_q == (($past(status_q) ^ $past(wdata)) & DEFINED_MASK)));
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_mask,
  input  logic  wr_global,
  input  word_t wdata,
  output word_t mask_q,
  output logic  global_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      global_q <= 1'b0;
    end else begin
      if (wr_mask)   mask_q   <= wdata & DEFINED_MASK;
      if (wr_global) global_q <= wdata[BIT_GLOBAL_EN];
    end
  end

  // R2
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_global |=> (global_q == $past(wdata[BIT_GLOBAL_EN])));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t status_q,
  input  word_t mask_q,
  input  logic  global_q,
  output logic  irq_q
);
  logic pend;

  assign pend = irq_pending(status_q, mask_q, global_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend;
  end

  // R8
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !global_q |=> !irq_q);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(global_q) && ($past(status_q & mask_q) != '0)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    OFF_GLOB = 'h1C,
  parameter logic [ADDR_W-1:0]    OFF_STAT = 'h20,
  parameter logic [ADDR_W-1:0]    OFF_MASK = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              xfer_done_i,
  input  logic              tx_underrun_i,
  input  logic              tx_half_empty_i,
  input  logic              rx_overrun_i,
  input  logic              rx_not_empty_i,
  input  logic              rx_full_i,
  output logic              irq_o
);
  logic     hit_glob, hit_stat, hit_mask;
  irq_src_t src;
  word_t    status_q, mask_q;
  logic     global_q;

  assign hit_glob = (reg_addr == OFF_GLOB);
  assign hit_stat = (reg_addr == OFF_STAT);
  assign hit_mask = (reg_addr == OFF_MASK);

  assign src = '{xfer_done: xfer_done_i, tx_underrun: tx_underrun_i,
                 tx_half_empty: tx_half_empty_i, rx_overrun: rx_overrun_i,
                 rx_not_empty: rx_not_empty_i, rx_full: rx_full_i};

  irq_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .wr_toggle(reg_wr && hit_stat),
    .wdata(reg_wdata), .src(src), .status_q(status_q));

  irq_enable_regs u_enables (
    .clk(clk), .rst_n(rst_n), .wr_mask(reg_wr && hit_mask),
    .wr_global(reg_wr && hit_glob), .wdata(reg_wdata),
    .mask_q(mask_q), .global_q(global_q));

  irq_out_gate u_gate (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q),
    .global_q(global_q), .irq_q(irq_o));

  always_comb begin
    reg_rdata = '0;
    if (hit_glob)      reg_rdata[BIT_GLOBAL_EN] = global_q;
    else if (hit_stat) reg_rdata = status_q;
    else if (hit_mask) reg_rdata = mask_q;
  end

  // R9
  undefined_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stat || hit_mask) |-> ((reg_rdata & ~DEFINED_MASK) == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h20;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_done_i = 0, tx_underrun_i = 0, tx_half_empty_i = 0;
  logic        rx_overrun_i = 0, rx_not_empty_i = 0, rx_full_i = 0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done_i(xfer_done_i),
    .tx_underrun_i(tx_underrun_i), .tx_half_empty_i(tx_half_empty_i),
    .rx_overrun_i(rx_overrun_i), .rx_not_empty_i(rx_not_empty_i),
    .rx_full_i(rx_full_i), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference
  logic [31:0] m_stat = 0, m_ier = 0;
  logic        m_gie = 0, m_irq = 0;
  localparam logic [31:0] VALID = 32'h0000_017C;

  always @(posedge clk) begin
    logic [31:0] s;
    logic        nirq;
    if (!rst_n) begin
      m_stat = 0; m_ier = 0; m_gie = 0; m_irq = 0;
    end else begin
      nirq = m_gie && ((m_stat & m_ier) != 0);
      s = m_stat;
      if (reg_wr && reg_addr == 8'h20) s = s ^ reg_wdata;
      if (xfer_done_i)     s = s | 32'h104;
      if (tx_underrun_i)   s = s | 32'h008;
      if (tx_half_empty_i) s = s | 32'h040;
      if (rx_overrun_i)    s = s | 32'h020;
      if (rx_not_empty_i)  s = s | 32'h100;
      if (rx_full_i)       s = s | 32'h010;
      if (reg_wr && reg_addr == 8'h28) m_ier = reg_wdata & VALID;
      if (reg_wr && reg_addr == 8'h1C) m_gie = reg_wdata[31];
      m_stat = s & VALID;
      m_irq  = nirq;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gie, 31'd0};
      8'h20:   return m_stat;
      8'h28:   return m_ier;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Advance one edge, compare against the model at the falling edge, drop strobes
  task automatic tick(input string tag);
    @(negedge clk);
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    check({tag, " read"}, reg_rdata, model_read(reg_addr));
    reg_wr = 0; xfer_done_i = 0; tx_underrun_i = 0; tx_half_empty_i = 0; rx_overrun_i = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    reg_addr = 8'h1C; #1 check("R1 glob", reg_rdata, 0);
    reg_addr = 8'h20; #1 check("R1 stat", reg_rdata, 0);
    reg_addr = 8'h28; #1 check("R1 mask", reg_rdata, 0);
    check("R1 irq", {31'd0, irq_o}, 0);

    // R3 mask keeps only defined bits
    wr(8'h28, 32'hFFFF_FFFF); tick("R3");
    check("R3 mask", reg_rdata, 32'h17C);
    // R2 global enable keeps only bit 31
    wr(8'h1C, 32'hFFFF_FFFF); tick("R2");
    check("R2 glob", reg_rdata, 32'h8000_0000);

    // R5 byte exchange, R8 latency
    reg_addr = 8'h20; xfer_done_i = 1; tick("R5");
    check("R5 stat", reg_rdata, 32'h104);
    check("R8 irq not yet", {31'd0, irq_o}, 0);
    tick("R8");
    check("R8 irq high", {31'd0, irq_o}, 1);

    // R4 XOR: clear bit 2, then set bit 3 by writing a one to a clear bit
    wr(8'h20, 32'h004); tick("R4");
    check("R4 clear", reg_rdata, 32'h100);
    wr(8'h20, 32'h008); tick("R4");
    check("R4 set", reg_rdata, 32'h108);
    wr(8'h20, 32'h108); tick("R4");
    check("R4 both", reg_rdata, 0);
    tick("R8");
    check("R8 irq low", {31'd0, irq_o}, 0);

    // R9 undefined positions and unmapped offsets
    wr(8'h20, 32'hFFFF_FE83); tick("R9");
    check("R9 stat", reg_rdata, 0);
    reg_addr = 8'h24; tick("R9");
    check("R9 unmapped", reg_rdata, 0);

    // R5 other pulses
    reg_addr = 8'h20; tx_underrun_i = 1; tx_half_empty_i = 1; rx_overrun_i = 1; tick("R5");
    check("R5 pulses", reg_rdata, 32'h068);
    wr(8'h20, 32'h068); tick("R4");

    // R6 levels survive a clearing write
    rx_not_empty_i = 1; tick("R6");
    check("R6 set", reg_rdata, 32'h100);
    wr(8'h20, 32'h100); tick("R6");
    check("R6 sticky", reg_rdata, 32'h100);
    rx_full_i = 1; tick("R6");
    check("R6 full", reg_rdata, 32'h110);
    wr(8'h20, 32'h110); tick("R6");
    check("R6 both sticky", reg_rdata, 32'h110);
    rx_not_empty_i = 0; rx_full_i = 0;
    wr(8'h20, 32'h110); tick("R6");
    check("R6 released", reg_rdata, 0);

    // R7 pulse beats toggle on the same bit
    xfer_done_i = 1; tick("R7");
    wr(8'h20, 32'h004); xfer_done_i = 1; tick("R7");
    check("R7 prio", reg_rdata, 32'h104);

    // R8 global enable off drops the line one edge later
    tick("R8");
    check("R8 irq on", {31'd0, irq_o}, 1);
    wr(8'h1C, 32'h0); tick("R8");
    check("R8 irq still", {31'd0, irq_o}, 1);
    tick("R8");
    check("R8 irq off", {31'd0, irq_o}, 0);

    for (int i = 0; i < 40; i++) begin
      reg_addr = (i % 3 == 0) ? 8'h1C : (i % 3 == 1) ? 8'h20 : 8'h28;
      if (i % 4 == 0) wr(reg_addr, 32'h0000_0F5A ^ (i * 32'h8000_1011));
      xfer_done_i = (i % 5 == 0); rx_overrun_i = (i % 7 == 0);
      rx_not_empty_i = (i % 11) < 3;
      tick("R8 mixed");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule